// File: doc/BRIEF.md
# First-Order Recursive Filter on a Shared Pipelined Multiplier

This block filters a stream of 18-bit signed samples with a first-order recursive filter in transposed form. For each sample it first forms the output as the b0-weighted input plus a stored state value. It then rebuilds the state from the b1-weighted input and the a1-weighted new output. All three products pass, one after another, through a single pipelined 18x18 multiplier inside the block. Every product is scaled back by 17 bits, so a gain of 131072 stands for 1.0.

A caller holds `start` high for one cycle with the sample and the three gains on the inputs. While the block works, `busy` is high. A one-cycle `done` pulse marks the point where `y_out` holds the new filtered value. The b0 and b1 products are issued back to back. The a1 product is issued in the same cycle the b0 result comes back, using the freshly computed output as its operand. The sequencer moves on when the multiplier signals a valid result, not after a fixed count, so any multiplier depth of one stage or more works unchanged.

Top module: `iir1_filter`

## Requirements
- R1: For each accepted sample x the block computes y = mem + P(b0*x). It then sets mem = P(b1*x) + P(a1*y). Every sum and every P result is kept to 18-bit two's complement and wraps on overflow.
- R2: P(p) rounds the 36-bit product p to the nearest multiple of 2^17, with ties going toward positive infinity (p + 2^16 shifted right arithmetically by 17). For example, with b0 = 65536 and zero state, x = 3 gives 2, and x = -3 gives -1.
- R3: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance. The sample and all gains are taken at the accepting edge.
- R4: A `start` pulse while `busy` is high is ignored, and so are changes to `x_in`, `b1_in` and `a1_in` during that time. The result equals the one for the originally accepted sample and gains.
- R5: `done` is high for exactly one cycle per accepted sample. It rises together with the fall of `busy`, and `y_out` holds the new output while `done` is high.
- R6: Counting the rising edge that accepts `start` as the first, `done` is registered by rising edge number 2*MUL_STAGES+3. The result is correct for every MUL_STAGES of 1 or more.
- R7: `y_out` changes only while `busy` is high. While idle it keeps the last result.
- R8: With b0 = 50, b1 = 300 and a1 = 131072-350, a constant input held for 2500 samples gives an output within 2 percent of that input.
- R9: A synchronous reset clears the output and the state to zero, drops `busy` and `done`, and puts the sequencer in the idle step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to filter `x_in` |
| x_in | input | 18 | Input sample, signed |
| b0_in | input | 18 | Feed-through gain, signed, 2^17 = 1.0 |
| b1_in | input | 18 | Input-to-state gain, signed, 2^17 = 1.0 |
| a1_in | input | 18 | Output-to-state gain, signed, 2^17 = 1.0 |
| y_out | output | 18 | Filtered output, signed, registered |
| busy | output | 1 | High while a sample is in progress |
| done | output | 1 | One-cycle pulse when `y_out` holds a new result |

## Verification
The properties assume that reset is high from time zero and that `start` is a synchronous level sampled at rising edges. They place no limit on sample or gain values, since every sum wraps by design. The stimulus drives `start` for exactly one cycle at falling edges. It also raises it again in the middle of some samples, together with scrambled gains and samples, so the ignore rule is exercised. Three copies with multiplier depths 1, 2 and 4 run in lockstep on the same stimulus and are compared against one arithmetic model.

// File: rtl/iir1_pkg.sv
package iir1_pkg;

  // Sequencer steps of one filter evaluation
  typedef enum logic [2:0] {
    ST_IDLE,      // waiting for start, issues x*b0 on accept
    ST_ISSUE_B1,  // issues x*b1 right behind the first product
    ST_WAIT_B0,   // waits for x*b0, forms output, issues y*a1
    ST_TAKE_B1,   // loads state with x*b1
    ST_WAIT_A1    // waits for y*a1, finishes the state update
  } step_e;

endpackage

// File: rtl/iir1_mul_pipe.sv
// Pipelined signed multiplier: one operand register stage followed by
// STAGES product stages; a valid flag travels alongside the data.
module iir1_mul_pipe #(
  parameter int W      = 18,
  parameter int STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic signed [W-1:0]   op_a,
  input  logic signed [W-1:0]   op_b,
  output logic signed [2*W-1:0] prod,
  output logic                  vld
);

  localparam int PW = 2 * W;

  logic signed [W-1:0]  a_q;
  logic signed [W-1:0]  b_q;
  logic                 req_q;
  logic signed [PW-1:0] p_q [STAGES];
  logic [STAGES-1:0]    v_q;

  // data path carries no reset so it maps onto a hard multiplier block
  always_ff @(posedge clk) begin
    a_q    <= op_a;
    b_q    <= op_b;
    p_q[0] <= a_q * b_q;
    for (int i = 1; i < STAGES; i++) begin
      p_q[i] <= p_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req;
  end

  generate
    if (STAGES == 1) begin : g_valid_single
      always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= req_q;
      end
    end else begin : g_valid_chain
      always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= {v_q[STAGES-2:0], req_q};
      end
    end
  endgenerate

  assign prod = p_q[STAGES-1];
  assign vld  = v_q[STAGES-1];

endmodule

// File: rtl/iir1_round.sv
// Scales a fixed-point product down by RADIX bits, rounding half up,
// and keeps the low OW bits in two's complement.
module iir1_round #(
  parameter int PW    = 36,
  parameter int OW    = 18,
  parameter int RADIX = 17
) (
  input  logic signed [PW-1:0] p,
  output logic signed [OW-1:0] q
);

  localparam logic signed [PW-1:0] HALF = {{(PW-1){1'b0}}, 1'b1} << (RADIX - 1);

  logic signed [PW-1:0] biased;

  assign biased = p + HALF;
  assign q      = OW'(biased >>> RADIX);

endmodule

// File: rtl/iir1_filter.sv
// First-order transposed recursive filter sharing one pipelined multiplier.
module iir1_filter
  import iir1_pkg::*;
#(
  parameter int W          = 18,
  parameter int RADIX      = 17,
  parameter int MUL_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] b0_in,
  input  logic signed [W-1:0] b1_in,
  input  logic signed [W-1:0] a1_in,
  output logic signed [W-1:0] y_out,
  output logic                busy,
  output logic                done
);

  localparam int PW = 2 * W;

  step_e               step;
  logic signed [W-1:0] x_hold;
  logic signed [W-1:0] b1_hold;
  logic signed [W-1:0] a1_hold;
  logic signed [W-1:0] mem;

  logic                m_req;
  logic signed [W-1:0] m_a;
  logic signed [W-1:0] m_b;
  logic signed [PW-1:0] m_p;
  logic                m_vld;
  logic signed [W-1:0] m_r;
  logic signed [W-1:0] y_next;

  iir1_mul_pipe #(
    .W      (W),
    .STAGES (MUL_STAGES)
  ) u_mul (
    .clk  (clk),
    .rst  (rst),
    .req  (m_req),
    .op_a (m_a),
    .op_b (m_b),
    .prod (m_p),
    .vld  (m_vld)
  );

  iir1_round #(
    .PW    (PW),
    .OW    (W),
    .RADIX (RADIX)
  ) u_round (
    .p (m_p),
    .q (m_r)
  );

  // state (or partial state) plus the product leaving the pipe
  assign y_next = mem + m_r;

  // multiplier issue: which operands enter the pipe this cycle
  always_comb begin
    m_req = 1'b0;
    m_a   = x_hold;
    m_b   = b1_hold;
    unique case (step)
      ST_IDLE: begin
        if (start) begin
          m_req = 1'b1;
          m_a   = x_in;
          m_b   = b0_in;
        end
      end
      ST_ISSUE_B1: m_req = 1'b1;
      ST_WAIT_B0: begin
        if (m_vld) begin
          m_req = 1'b1;
          m_a   = y_next;
          m_b   = a1_hold;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step    <= ST_IDLE;
      x_hold  <= '0;
      b1_hold <= '0;
      a1_hold <= '0;
      mem     <= '0;
      y_out   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (step)
        ST_IDLE: begin
          if (start) begin
            x_hold  <= x_in;
            b1_hold <= b1_in;
            a1_hold <= a1_in;
            busy    <= 1'b1;
            step    <= ST_ISSUE_B1;
          end
        end
        ST_ISSUE_B1: step <= ST_WAIT_B0;
        ST_WAIT_B0: begin
          if (m_vld) begin
            y_out <= y_next;
            step  <= ST_TAKE_B1;
          end
        end
        ST_TAKE_B1: begin
          // x*b1 trails x*b0 by exactly one cycle in the pipe
          mem  <= m_r;
          step <= ST_WAIT_A1;
        end
        ST_WAIT_A1: begin
          if (m_vld) begin
            mem  <= y_next;
            done <= 1'b1;
            busy <= 1'b0;
            step <= ST_IDLE;
          end
        end
        default: step <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/iir1_filter_chk.sv
module iir1_filter_chk #(
  parameter int W = 18
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic signed [W-1:0] y_out,
  input logic signed [W-1:0] x_hold
);

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!busy && !done && y_out == '0));

  assert_accept_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_sample_held_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(x_hold));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_output_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(y_out) |-> $past(busy));

endmodule

bind iir1_filter iir1_filter_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .y_out  (y_out),
  .x_hold (x_hold)
);

// File: tb/iir1_filter_bench.sv
module iir1_filter_bench;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start = 1'b0;
  logic signed [17:0] x_in = '0;
  logic signed [17:0] b0_in = '0;
  logic signed [17:0] b1_in = '0;
  logic signed [17:0] a1_in = '0;
  logic signed [17:0] y_o [3];
  logic               bz [3];
  logic               dn [3];

  int total = 0;
  int bad   = 0;

  longint g0, g1, ga;
  longint mem_m, y_m;

  always #2.5 clk = ~clk;

  iir1_filter #(.MUL_STAGES(1)) u_iir1_filter_s1 (
    .clk(clk), .rst(rst), .start(start), .x_in(x_in), .b0_in(b0_in),
    .b1_in(b1_in), .a1_in(a1_in), .y_out(y_o[0]), .busy(bz[0]), .done(dn[0]));

  iir1_filter u_iir1_filter (
    .clk(clk), .rst(rst), .start(start), .x_in(x_in), .b0_in(b0_in),
    .b1_in(b1_in), .a1_in(a1_in), .y_out(y_o[1]), .busy(bz[1]), .done(dn[1]));

  iir1_filter #(.MUL_STAGES(4)) u_iir1_filter_s4 (
    .clk(clk), .rst(rst), .start(start), .x_in(x_in), .b0_in(b0_in),
    .b1_in(b1_in), .a1_in(a1_in), .y_out(y_o[2]), .busy(bz[2]), .done(dn[2]));

  function automatic longint w18(longint v);
    longint t = v & 64'h3FFFF;
    if (t >= 131072) t -= 262144;
    return t;
  endfunction

  function automatic longint rnd(longint p);
    return w18((p + 65536) >>> 17);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst   = 1'b1;
    start = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(y_o[k] == 0 && !bz[k] && !dn[k], "R9", longint'(y_o[k]), 0);
    end
    rst   = 1'b0;
    mem_m = 0;
    y_m   = 0;
  endtask

  // one filter evaluation; tag names the requirement the value check covers
  task automatic do_sample(longint x, bit poke, string tag);
    int lat [3];
    int exp_lat [3];
    exp_lat = '{5, 7, 11};
    lat     = '{0, 0, 0};
    y_m   = w18(mem_m + rnd(x * g0));
    mem_m = w18(rnd(x * g1) + rnd(y_m * ga));
    @(negedge clk);
    x_in  = 18'(x);
    b0_in = 18'(g0);
    b1_in = 18'(g1);
    a1_in = 18'(ga);
    start = 1'b1;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (n == 1) begin
        start = 1'b0;
        for (int k = 0; k < 3; k++) chk(bz[k], "R3", longint'(bz[k]), 1);
      end
      if (poke && n == 2) begin
        start = 1'b1;
        x_in  = ~x_in;
        b1_in = ~b1_in;
        a1_in = ~a1_in;
      end
      if (poke && n == 3) start = 1'b0;
      for (int k = 0; k < 3; k++) begin
        if (lat[k] == 0 && dn[k]) begin
          lat[k] = n;
          chk(y_o[k] == y_m, poke ? "R4" : tag, longint'(y_o[k]), y_m);
          chk(!bz[k], "R5", longint'(bz[k]), 0);
        end else if (lat[k] != 0 && n == lat[k] + 1) begin
          chk(!dn[k], "R5", longint'(dn[k]), 0);
        end
      end
      if (lat[0] != 0 && lat[1] != 0 && lat[2] != 0 &&
          n > lat[0] && n > lat[1] && n > lat[2]) break;
    end
    for (int k = 0; k < 3; k++) chk(lat[k] == exp_lat[k], "R6", lat[k], exp_lat[k]);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) chk(y_o[k] == y_m, "R7", longint'(y_o[k]), y_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint sets [4][3];
    sets = '{'{50, 300, 130722}, '{65536, -40000, 20000},
             '{-131072, 131071, -65536}, '{12345, -777, 100000}};
    do_reset();

    // rounding: half gain, zero state, so y is just the rounded product
    g0 = 65536; g1 = 0; ga = 0;
    do_sample(1, 1'b0, "R2");
    chk(y_m == 1, "R2", y_m, 1);
    do_sample(-1, 1'b0, "R2");
    do_sample(3, 1'b0, "R2");
    chk(y_m == 2, "R2", y_m, 2);
    do_sample(-3, 1'b0, "R2");
    chk(y_m == -1, "R2", y_m, -1);
    do_sample(5, 1'b0, "R2");
    do_sample(-5, 1'b0, "R2");

    // sweep of the sample range under several gain sets (R1), with
    // mid-sample start pulses and scrambled inputs (R4)
    for (int s = 0; s < 4; s++) begin
      g0 = sets[s][0]; g1 = sets[s][1]; ga = sets[s][2];
      for (int i = 0; i < 64; i++) begin
        do_sample(w18(-131072 + i * 4099 + s * 17), (i % 5) == 2, "R1");
      end
    end

    // DC behaviour with unity-gain coefficients (R8), after a fresh reset
    do_reset();
    g0 = 50; g1 = 300; ga = 131072 - 350;
    for (int i = 0; i < 2500; i++) do_sample(15000, 1'b0, "R8");
    for (int k = 0; k < 3; k++)
      chk(y_o[k] >= 15000 - 300 && y_o[k] <= 15000 + 300, "R8", longint'(y_o[k]), 15000);
    for (int i = 0; i < 2500; i++) do_sample(-20000, 1'b0, "R8");
    for (int k = 0; k < 3; k++)
      chk(y_o[k] >= -20000 - 400 && y_o[k] <= -20000 + 400, "R8", longint'(y_o[k]), -20000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule